// File: doc/BRIEF.md
# Half-Duplex Collision Backoff Controller

This block paces retransmissions after collisions on a shared half-duplex medium. A frame in flight is tracked from its start strobe to its done strobe. Each collision seen during that window bumps an attempt count. A random wait of `r` slot times is drawn from a free-running LFSR, masked to `k = min(n, L)` bits. Here `n` is the number of collisions so far in the frame and `L` is a cap picked by a 2-bit limit code. A slot timer then counts that wait down in units of `SLOT_BITS` bit-time ticks and raises a one-cycle retry permit at the end.

Two conditions end a frame with an abort pulse and a sticky excessive-collision flag. The first is a collision while single-attempt mode is set. The second is the collision that arrives on the final permitted attempt. With the half-duplex enable low, collisions have no effect at all. The surrounding transmitter starts a frame, reacts to the permit by resending, and reports the outcome from the flag.

Top module: `hdx_backoff_ctrl`

## Requirements
- R1: After synchronous active-low reset, `retry_ok_o`, `backoff_busy_o`, `abort_o` and `excess_col_o` are all 0.
- R2: A backoff accepted at clock edge E0 holds `backoff_busy_o` high until `retry_ok_o` pulses for one cycle at edge E0 + r·SLOT_BITS + 1 (ticks held high). `backoff_busy_o` is low in that pulse cycle. The default SLOT_BITS is 512.
- R3: For the n-th collision of a frame, r lies in 0 .. 2^k − 1 with k = min(n, L). Limit code 2'b00 gives L=10, 2'b01 gives 8, 2'b10 gives 4 and 2'b11 gives 1.
- R4: With `single_attempt_i` high, the first collision raises `abort_o` for one cycle and sets `excess_col_o` one clock later, and no backoff starts.
- R5: A frame permits MAX_ATTEMPTS (default 16) attempts. The collision on the last attempt aborts it with `excess_col_o` set, after MAX_ATTEMPTS−1 backoffs.
- R6: A collision strobe during a backoff is ignored. It causes no abort, no restart of the wait, and no change in its length.
- R7: While `half_duplex_i` is low, collisions start no backoff and cause no abort.
- R8: `frame_start_i` resets the attempt count to 1 and clears `excess_col_o`. After `frame_done_i` (or an abort), collisions are ignored until the next frame start.
- R9: The slot countdown advances only on cycles with `bit_tick_i` high. With ticks held low, a backoff with r ≥ 1 stays busy indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| half_duplex_i | input | 1 | 1 = shared medium, backoff logic active |
| frame_start_i | input | 1 | Strobe: a new frame begins transmission |
| frame_done_i | input | 1 | Strobe: the current frame completed |
| collision_i | input | 1 | Strobe: collision detected on the medium |
| limit_sel_i | input | 2 | Exponent cap code (00:10, 01:8, 10:4, 11:1) |
| single_attempt_i | input | 1 | 1 = abort on first collision, no retries |
| bit_tick_i | input | 1 | One pulse per bit time |
| retry_ok_o | output | 1 | One-cycle permit to retransmit |
| backoff_busy_o | output | 1 | High while a backoff wait is in progress |
| abort_o | output | 1 | One-cycle pulse: frame abandoned |
| excess_col_o | output | 1 | Sticky excessive-collision status for the current frame |

## Verification
Every output is registered. `backoff_busy_o`, `abort_o` and the state change are visible one edge after a collision strobe is sampled, and `excess_col_o` one edge after `abort_o`. The permit follows at exactly r·SLOT_BITS + 1 edges, so the bench measures that distance and requires it to be one more than a multiple of the slot length. It then checks the recovered r against the cap for the attempt number. Inputs are driven and outputs sampled on the falling edge, so each check reads the state produced by the preceding rising edge. The bench shrinks SLOT_BITS so that long exponent sweeps stay short in cycles.

// File: rtl/hbo_pkg.sv
// Shared types and constants for the half-duplex backoff controller.
// Assumes: exponent caps never exceed MAX_EXP.
package hbo_pkg;
    localparam int MAX_EXP = 10;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TXING = 2'd1,
        ST_WAIT = 2'd2
    } hbo_state_e;

    // Maps the 2-bit limit code to the exponent cap L.
    function automatic logic [3:0] exp_cap(input logic [1:0] code);
        case (code)
            2'b00:   return 4'd10;
            2'b01:   return 4'd8;
            2'b10:   return 4'd4;
            default: return 4'd1;
        endcase
    endfunction
endpackage

// File: rtl/hbo_lfsr.sv
// Free-running Galois LFSR, the random source for backoff draws.
// Assumes: SEED is nonzero and TAPS describe a maximal polynomial.
module hbo_lfsr #(
    parameter int W = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] rnd_o
);
    logic [W-1:0] state;

    // Advance the shift register every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEED;
        else        state <= (state >> 1) ^ (state[0] ? TAPS : '0);
    end

    assign rnd_o = state;

    AST_LFSR_ALIVE: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0); // R3
endmodule

// File: rtl/hbo_slot_timer.sv
// Counts down a number of slot times, each SLOT_BITS bit ticks long.
// Assumes: load_i and run_i are never high together; SLOT_BITS >= 2.
module hbo_slot_timer #(
    parameter int SLOT_BITS = 512,
    parameter int RAND_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [RAND_W-1:0] load_val_i,
    input  logic              run_i,
    input  logic              tick_i,
    output logic              done_o
);
    localparam int BIT_W = $clog2(SLOT_BITS);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SLOT_BITS - 1);

    logic [RAND_W-1:0] slots_left;
    logic [BIT_W-1:0]  bit_cnt;

    // Load a new wait, or step the bit and slot counters on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots_left <= '0;
            bit_cnt    <= '0;
        end else if (load_i) begin
            slots_left <= load_val_i;
            bit_cnt    <= '0;
        end else if (run_i && tick_i && slots_left != '0) begin
            if (bit_cnt == LAST_BIT) begin
                bit_cnt    <= '0;
                slots_left <= slots_left - 1'b1;
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    assign done_o = run_i && (slots_left == '0);

    AST_SLOTS_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> slots_left <= $past(slots_left)); // R2
    AST_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !tick_i) |=> $stable(slots_left) && $stable(bit_cnt)); // R9
endmodule

// File: rtl/hdx_backoff_ctrl.sv
// Half-duplex collision backoff controller: tracks attempts per frame,
// draws a masked random slot count per collision, times the wait and
// permits a retry, or aborts on single-attempt mode or attempt exhaustion.
// Assumes: strobes are one cycle wide; bit_tick_i is synchronous to clk.
module hdx_backoff_ctrl #(
    parameter int SLOT_BITS = 512,
    parameter int MAX_ATTEMPTS = 16,
    parameter int LFSR_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       half_duplex_i,
    input  logic       frame_start_i,
    input  logic       frame_done_i,
    input  logic       collision_i,
    input  logic [1:0] limit_sel_i,
    input  logic       single_attempt_i,
    input  logic       bit_tick_i,
    output logic       retry_ok_o,
    output logic       backoff_busy_o,
    output logic       abort_o,
    output logic       excess_col_o
);
    import hbo_pkg::*;

    localparam int RAND_W = MAX_EXP;
    localparam int ATT_W = $clog2(MAX_ATTEMPTS + 1);
    localparam logic [ATT_W-1:0] ATT_LAST = ATT_W'(MAX_ATTEMPTS);

    hbo_state_e        state;
    logic [ATT_W-1:0]  attempts;
    logic [LFSR_W-1:0] rnd;
    logic [ATT_W-1:0]  cap_w;
    logic [ATT_W-1:0]  k_w;
    logic [RAND_W-1:0] mask;
    logic [RAND_W-1:0] draw;
    logic              accept;
    logic              give_up;
    logic              tmr_load;
    logic              tmr_done;

    hbo_lfsr #(.W(LFSR_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd_o (rnd)
    );

    // Exponent k = min(n, L) and the matching low-bit mask.
    always_comb begin
        cap_w = ATT_W'(exp_cap(limit_sel_i));
        k_w   = (attempts < cap_w) ? attempts : cap_w;
        for (int i = 0; i < RAND_W; i++) begin
            mask[i] = (ATT_W'(i) < k_w);
        end
        draw = rnd[RAND_W-1:0] & mask;
    end

    // Collision qualification and the retry-or-abort decision.
    assign accept   = (state == ST_TXING) && half_duplex_i && collision_i
                      && !frame_start_i && !frame_done_i;
    assign give_up  = single_attempt_i || (attempts >= ATT_LAST);
    assign tmr_load = accept && !give_up;

    hbo_slot_timer #(.SLOT_BITS(SLOT_BITS), .RAND_W(RAND_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (draw),
        .run_i      (state == ST_WAIT),
        .tick_i     (bit_tick_i),
        .done_o     (tmr_done)
    );

    // Frame state machine, attempt count and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            attempts     <= '0;
            retry_ok_o   <= 1'b0;
            abort_o      <= 1'b0;
            excess_col_o <= 1'b0;
        end else begin
            retry_ok_o <= 1'b0;
            abort_o    <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (frame_start_i) begin
                        state        <= ST_TXING;
                        attempts     <= ATT_W'(1);
                        excess_col_o <= 1'b0;
                    end
                end
                ST_TXING: begin
                    if (frame_start_i) begin
                        attempts     <= ATT_W'(1);
                        excess_col_o <= 1'b0;
                    end else if (frame_done_i) begin
                        state <= ST_IDLE;
                    end else if (accept && give_up) begin
                        state   <= ST_IDLE;
                        abort_o <= 1'b1;
                    end else if (accept) begin
                        state    <= ST_WAIT;
                        attempts <= attempts + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (tmr_done) begin
                        state      <= ST_TXING;
                        retry_ok_o <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
            if (abort_o) excess_col_o <= 1'b1;
        end
    end

    assign backoff_busy_o = (state == ST_WAIT);

    AST_ABORT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> $past(collision_i && half_duplex_i)); // R4
    AST_SINGLE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && single_attempt_i) |=> abort_o && !backoff_busy_o); // R4
    AST_RETRY_ENDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        retry_ok_o |-> $past(backoff_busy_o) && !backoff_busy_o); // R2
    AST_WAIT_IGNORES_COLL: assert property (@(posedge clk) disable iff (!rst_n)
        backoff_busy_o |=> !abort_o); // R6
    AST_FDX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !half_duplex_i |=> !abort_o && !$rose(backoff_busy_o)); // R7
    AST_ATTEMPT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        attempts <= ATT_LAST); // R5
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start_i && state != ST_WAIT) |=> !excess_col_o); // R8
endmodule

// File: tb/hdx_backoff_ctrl_bench.sv
module hdx_backoff_ctrl_bench;
    localparam int SLOT = 8;
    localparam int MAXW = 1023 * SLOT + 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic half_duplex_i = 1'b1;
    logic frame_start_i = 1'b0;
    logic frame_done_i = 1'b0;
    logic collision_i = 1'b0;
    logic [1:0] limit_sel_i = 2'b00;
    logic single_attempt_i = 1'b0;
    logic bit_tick_i = 1'b1;
    logic retry_ok_o, backoff_busy_o, abort_o, excess_col_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    hdx_backoff_ctrl #(.SLOT_BITS(SLOT)) u_hdx_backoff_ctrl (
        .clk(clk), .rst_n(rst_n), .half_duplex_i(half_duplex_i),
        .frame_start_i(frame_start_i), .frame_done_i(frame_done_i),
        .collision_i(collision_i), .limit_sel_i(limit_sel_i),
        .single_attempt_i(single_attempt_i), .bit_tick_i(bit_tick_i),
        .retry_ok_o(retry_ok_o), .backoff_busy_o(backoff_busy_o),
        .abort_o(abort_o), .excess_col_o(excess_col_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_start();
        frame_start_i = 1'b1; step(); frame_start_i = 1'b0;
    endtask

    task automatic pulse_done();
        frame_done_i = 1'b1; step(); frame_done_i = 1'b0;
    endtask

    task automatic pulse_coll();
        collision_i = 1'b1; step(); collision_i = 1'b0;
    endtask

    function automatic int cap_of(input logic [1:0] c);
        case (c)
            2'b00: return 10;
            2'b01: return 8;
            2'b10: return 4;
            default: return 1;
        endcase
    endfunction

    // Collide, then count edges until the retry permit; returns r or -1.
    task automatic collide_measure(input string req, output int r);
        int j = 0;
        bit busy_ok = 1'b1;
        pulse_coll();
        check(backoff_busy_o == 1'b1 && abort_o == 1'b0, {req, " busy after collision"},
              backoff_busy_o, 1);
        while (!retry_ok_o && j < MAXW) begin
            step(); j++;
            if (!retry_ok_o && !backoff_busy_o) busy_ok = 1'b0;
        end
        check(busy_ok && retry_ok_o && !backoff_busy_o, {req, " busy until permit"},
              busy_ok, 1);
        check((j - 1) % SLOT == 0, "R2 wait length multiple of slot", (j - 1) % SLOT, 0);
        r = (j - 1) / SLOT;
        step();
        check(retry_ok_o == 1'b0, "R2 permit one cycle", retry_ok_o, 0);
    endtask

    task automatic t_reset();
        check({retry_ok_o, backoff_busy_o, abort_o, excess_col_o} == 4'b0, "R1 in reset",
              {retry_ok_o, backoff_busy_o, abort_o, excess_col_o}, 0);
        rst_n = 1'b1; step();
        check({retry_ok_o, backoff_busy_o, abort_o, excess_col_o} == 4'b0, "R1 after reset",
              {retry_ok_o, backoff_busy_o, abort_o, excess_col_o}, 0);
    endtask

    task automatic t_limits();
        for (int c = 0; c < 4; c++) begin
            int maxr = 0;
            limit_sel_i = 2'(c);
            pulse_start();
            for (int n = 1; n <= 11; n++) begin
                int r, k;
                k = (n < cap_of(2'(c))) ? n : cap_of(2'(c));
                collide_measure("R2", r);
                check(r >= 0 && r <= (1 << k) - 1, "R3 draw within 2^k-1", r, (1 << k) - 1);
                if (r > maxr) maxr = r;
            end
            if (c == 0) check(maxr > 15, "R3 cap 10 reaches wide draws", maxr, 16);
            pulse_done();
        end
    endtask

    task automatic t_single();
        single_attempt_i = 1'b1;
        pulse_start();
        pulse_coll();
        check(abort_o && !backoff_busy_o, "R4 abort on first collision", abort_o, 1);
        step();
        check(!abort_o && excess_col_o, "R4 abort pulse and sticky status",
              {abort_o, excess_col_o}, 1);
        pulse_coll();
        check(!abort_o && !backoff_busy_o, "R8 collision ignored after abort", abort_o, 0);
        single_attempt_i = 1'b0;
    endtask

    task automatic t_sixteen(input string req);
        int r;
        bit clean = 1'b1;
        for (int i = 1; i < 16; i++) begin
            collide_measure(req, r);
            if (excess_col_o) clean = 1'b0;
        end
        check(clean, {req, " no abort during 15 backoffs"}, clean, 1);
        pulse_coll();
        check(abort_o && !backoff_busy_o, {req, " 16th collision aborts"}, abort_o, 1);
        step();
        check(excess_col_o, {req, " excessive status set"}, excess_col_o, 1);
    endtask

    task automatic t_ignore();
        bit found = 1'b0;
        limit_sel_i = 2'b00;
        pulse_start();
        for (int tries = 0; tries < 9 && !found; tries++) begin
            int j = 1;
            pulse_coll();
            step();
            if (retry_ok_o) begin
                step();
            end else begin
                found = 1'b1;
                collision_i = 1'b1; step(); collision_i = 1'b0; j++;
                check(!abort_o && backoff_busy_o, "R6 collision during wait ignored",
                      abort_o, 0);
                while (!retry_ok_o && j < MAXW) begin step(); j++; end
                check(retry_ok_o && (j - 1) % SLOT == 0, "R6 wait length unchanged",
                      (j - 1) % SLOT, 0);
                step();
            end
        end
        check(found, "R6 found nonzero wait", found, 1);
        pulse_done();
    endtask

    task automatic t_fdx();
        int r;
        half_duplex_i = 1'b0;
        pulse_start();
        pulse_coll();
        step();
        check(!backoff_busy_o && !abort_o && !excess_col_o, "R7 full duplex ignores collision",
              {backoff_busy_o, abort_o}, 0);
        half_duplex_i = 1'b1;
        collide_measure("R7", r);
        check(r <= 1, "R7 first draw after enabling", r, 1);
        pulse_done();
    endtask

    task automatic t_frame();
        int r;
        single_attempt_i = 1'b1;
        pulse_start();
        pulse_coll();
        step();
        check(excess_col_o, "R8 status set before restart", excess_col_o, 1);
        single_attempt_i = 1'b0;
        limit_sel_i = 2'b11;
        pulse_start();
        check(!excess_col_o, "R8 frame start clears status", excess_col_o, 0);
        for (int i = 0; i < 3; i++) collide_measure("R8", r);
        pulse_start();
        t_sixteen("R8");
        pulse_start();
        pulse_done();
        pulse_coll();
        check(!backoff_busy_o && !abort_o, "R8 collision after done ignored",
              backoff_busy_o, 0);
    endtask

    task automatic t_tick();
        bit found = 1'b0;
        limit_sel_i = 2'b00;
        pulse_start();
        for (int tries = 0; tries < 9 && !found; tries++) begin
            bit held = 1'b1;
            int j = 0;
            bit_tick_i = 1'b0;
            pulse_coll();
            step();
            if (retry_ok_o) begin
                step();
            end else begin
                found = 1'b1;
                for (int i = 0; i < 60; i++) begin
                    step();
                    if (!backoff_busy_o || retry_ok_o) held = 1'b0;
                end
                check(held, "R9 no progress without ticks", held, 1);
                bit_tick_i = 1'b1;
                while (!retry_ok_o && j < MAXW) begin step(); j++; end
                check(retry_ok_o, "R9 resumes with ticks", retry_ok_o, 1);
                step();
            end
        end
        bit_tick_i = 1'b1;
        check(found, "R9 found nonzero wait", found, 1);
        pulse_done();
    endtask

    initial begin
        step(); step();
        t_reset();
        t_limits();
        t_single();
        limit_sel_i = 2'b10;
        pulse_start();
        t_sixteen("R5");
        t_ignore();
        t_fdx();
        t_frame();
        t_tick();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule